// File: doc/BRIEF.md
# Dual-Port DDR Burst SRAM Core

A synthesizable on-chip memory with one read port and one write port that run at the same time. Both ports take their address from a single shared address bus: the bus carries the read address at the rising edge of `clk_i` and the write address at the falling edge. Each location holds two data words. Every access moves both words as a two-beat burst, with one beat on each clock edge.

Read data leaves on a dedicated output bus and write data arrives on a dedicated input bus, so no bus ever changes direction. Each port has its own active-low select, and a deselected port does nothing in that cycle. Write beats carry per-byte enables. Writes are staged and committed to the array only after both beats have arrived. A read still returns the newest data, because it merges a staged write byte by byte.

The design uses one clock. Its rising edge acts as the main clock and its falling edge acts as the complementary clock, for both input capture and output launch.

Top module: `ddr_burst_sram`

## Requirements
- R1: If `rd_sel_ni` is low at the rising edge of cycle n, `rvalid_o` is high for all of cycle n+1. In that cycle `rdata_o` shows word 0 of the addressed location while `clk_i` is high and word 1 while `clk_i` is low.
- R2: If `wr_sel_ni` is low at the falling edge of cycle n, `addr_i` is taken as the write address at that edge. Word 0 and its enables are taken from `wdata_i`/`wbe_i` at the rising edge of cycle n+1, and word 1 and its enables at the falling edge of cycle n+1.
- R3: If `rd_sel_ni` is high at the rising edge of cycle n, `rvalid_o` is low for all of cycle n+1 and no data is returned.
- R4: If `wr_sel_ni` is high at the falling edge, the array stays unchanged, whatever appears on `addr_i`, `wdata_i` and `wbe_i`.
- R5: Bit b of `wbe_i` (active high) guards bits 8b+7..8b of the beat it comes with. A low bit leaves that byte of the stored word unchanged.
- R6: A read at the rising edge of cycle n returns the effect of every write whose address was taken at or before the falling edge of cycle n-1, merged byte by byte. This includes a write whose beats are still arriving.
- R7: A write whose address is taken at the falling edge of cycle n is not seen by the read taken at the rising edge of cycle n.
- R8: While `rvalid_o` is low, `rdata_o` is all zeros in both clock phases.
- R9: While `rst_ni` is low, `rvalid_o` is low. After reset every location reads as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock; rising edge is the main edge, falling edge is the complementary edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | ADDR_W | Shared address: read address at the rising edge, write address at the falling edge |
| rd_sel_ni | input | 1 | Read port select, active low, sampled at the rising edge |
| wr_sel_ni | input | 1 | Write port select, active low, sampled at the falling edge |
| wdata_i | input | NBYTES*BYTE_W | Write beat data |
| wbe_i | input | NBYTES | Per-byte write enables of the current beat, active high |
| rdata_o | output | NBYTES*BYTE_W | Read beat data: word 0 in the high phase, word 1 in the low phase |
| rvalid_o | output | 1 | High for the whole cycle in which a read burst is returned |

## Verification
The assertions assume that the selects are sampled only on their own edges and that reset is asserted at time zero. They also assume `rdata_o` is sampled inside a phase and not at an edge. Given these, they tie each select to the valid flag two sampling edges later and require zero data whenever the flag is low. The stimulus changes inputs only 2 ns after each edge. Read address and word-0 data are driven in the low phase, and write address and word-1 data in the high phase, so every sampled value is steady at its edge. A small address range forces frequent hits on staged and just-committed writes.

// File: rtl/dbs_pkg.sv
`timescale 1ns/1ps
package dbs_pkg;
  localparam int unsigned DBS_ADDR_W = 4;
  localparam int unsigned DBS_BYTE_W = 8;
  localparam int unsigned DBS_NBYTES = 2;
endpackage

// File: rtl/dbs_wr_path.sv
`timescale 1ns/1ps
module dbs_wr_path #(
  parameter int unsigned ADDR_W = 4,
  parameter int unsigned NBYTES = 2,
  parameter int unsigned BYTE_W = 8,
  localparam int unsigned DW = NBYTES * BYTE_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              wr_sel_ni,
  input  logic [DW-1:0]     wdata_i,
  input  logic [NBYTES-1:0] wbe_i,
  output logic              stg_v_o,
  output logic [ADDR_W-1:0] stg_a_o,
  output logic [DW-1:0]     stg_d0_o,
  output logic [DW-1:0]     stg_d1_o,
  output logic [NBYTES-1:0] stg_b0_o,
  output logic [NBYTES-1:0] stg_b1_o
);
  logic              wv_q;
  logic [ADDR_W-1:0] wa_q;

  // falling edge: write address, then second beat of the staged write
  always_ff @(negedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wv_q     <= 1'b0;
      wa_q     <= '0;
      stg_d1_o <= '0;
      stg_b1_o <= '0;
    end else begin
      wv_q <= ~wr_sel_ni;
      wa_q <= addr_i;
      if (stg_v_o) begin
        stg_d1_o <= wdata_i;
        stg_b1_o <= wbe_i;
      end
    end
  end

  // rising edge: first beat opens the staging slot
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stg_v_o  <= 1'b0;
      stg_a_o  <= '0;
      stg_d0_o <= '0;
      stg_b0_o <= '0;
    end else begin
      stg_v_o <= wv_q;
      if (wv_q) begin
        stg_a_o  <= wa_q;
        stg_d0_o <= wdata_i;
        stg_b0_o <= wbe_i;
      end
    end
  end
endmodule

// File: rtl/dbs_array.sv
`timescale 1ns/1ps
module dbs_array #(
  parameter int unsigned ADDR_W = 4,
  parameter int unsigned NBYTES = 2,
  parameter int unsigned BYTE_W = 8,
  localparam int unsigned DW    = NBYTES * BYTE_W,
  localparam int unsigned DEPTH = 1 << ADDR_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cm_v_i,
  input  logic [ADDR_W-1:0] cm_a_i,
  input  logic [DW-1:0]     cm_d0_i,
  input  logic [DW-1:0]     cm_d1_i,
  input  logic [NBYTES-1:0] cm_b0_i,
  input  logic [NBYTES-1:0] cm_b1_i,
  input  logic [ADDR_W-1:0] rd_a0_i,
  input  logic [ADDR_W-1:0] rd_a1_i,
  output logic [DW-1:0]     rd_d0_o,
  output logic [DW-1:0]     rd_d1_o
);
  logic [DW-1:0] mem0_q [DEPTH];
  logic [DW-1:0] mem1_q [DEPTH];

  // commit of a complete staged write, both words at once
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) begin
        mem0_q[i] <= '0;
        mem1_q[i] <= '0;
      end
    end else if (cm_v_i) begin
      for (int b = 0; b < NBYTES; b++) begin
        if (cm_b0_i[b]) mem0_q[cm_a_i][b*BYTE_W +: BYTE_W] <= cm_d0_i[b*BYTE_W +: BYTE_W];
        if (cm_b1_i[b]) mem1_q[cm_a_i][b*BYTE_W +: BYTE_W] <= cm_d1_i[b*BYTE_W +: BYTE_W];
      end
    end
  end

  assign rd_d0_o = mem0_q[rd_a0_i];
  assign rd_d1_o = mem1_q[rd_a1_i];
endmodule

// File: rtl/dbs_rd_path.sv
`timescale 1ns/1ps
module dbs_rd_path #(
  parameter int unsigned ADDR_W = 4,
  parameter int unsigned NBYTES = 2,
  parameter int unsigned BYTE_W = 8,
  localparam int unsigned DW = NBYTES * BYTE_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              rd_sel_ni,
  input  logic              stg_v_i,
  input  logic [ADDR_W-1:0] stg_a_i,
  input  logic [DW-1:0]     stg_d0_i,
  input  logic [NBYTES-1:0] stg_b0_i,
  input  logic [DW-1:0]     arr_d0_i,
  input  logic [DW-1:0]     arr_d1_i,
  output logic [ADDR_W-1:0] arr_a0_o,
  output logic [ADDR_W-1:0] arr_a1_o,
  output logic [DW-1:0]     rdata_o,
  output logic              rvalid_o
);
  logic              req_v_q, beat_v_q;
  logic [ADDR_W-1:0] req_a_q, beat_a_q;
  logic [DW-1:0]     w0_q, w1_q, w0_mrg;
  logic              stg_hit;

  assign stg_hit  = stg_v_i && (stg_a_i == req_a_q);
  assign arr_a0_o = req_a_q;
  assign arr_a1_o = beat_a_q;

  // word 0: staged write not yet in the array, merge its enabled bytes
  for (genvar b = 0; b < NBYTES; b++) begin : g_mrg
    assign w0_mrg[b*BYTE_W +: BYTE_W] = (stg_hit && stg_b0_i[b]) ?
        stg_d0_i[b*BYTE_W +: BYTE_W] : arr_d0_i[b*BYTE_W +: BYTE_W];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      req_v_q  <= 1'b0;
      req_a_q  <= '0;
      beat_v_q <= 1'b0;
      beat_a_q <= '0;
      w0_q     <= '0;
    end else begin
      req_v_q  <= ~rd_sel_ni;
      req_a_q  <= addr_i;
      beat_v_q <= req_v_q;
      beat_a_q <= req_a_q;
      w0_q     <= req_v_q ? w0_mrg : '0;
    end
  end

  // word 1: the staged write has committed at the preceding rising edge
  always_ff @(negedge clk_i or negedge rst_ni) begin
    if (!rst_ni) w1_q <= '0;
    else         w1_q <= beat_v_q ? arr_d1_i : '0;
  end

  assign rdata_o  = clk_i ? w0_q : w1_q;
  assign rvalid_o = beat_v_q;
endmodule

// File: rtl/ddr_burst_sram.sv
`timescale 1ns/1ps
module ddr_burst_sram
  import dbs_pkg::*;
#(
  parameter int unsigned ADDR_W = DBS_ADDR_W,
  parameter int unsigned NBYTES = DBS_NBYTES,
  parameter int unsigned BYTE_W = DBS_BYTE_W,
  localparam int unsigned DW = NBYTES * BYTE_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              rd_sel_ni,
  input  logic              wr_sel_ni,
  input  logic [DW-1:0]     wdata_i,
  input  logic [NBYTES-1:0] wbe_i,
  output logic [DW-1:0]     rdata_o,
  output logic              rvalid_o
);
  logic              stg_v;
  logic [ADDR_W-1:0] stg_a, arr_a0, arr_a1;
  logic [DW-1:0]     stg_d0, stg_d1, arr_d0, arr_d1;
  logic [NBYTES-1:0] stg_b0, stg_b1;

  dbs_wr_path #(.ADDR_W(ADDR_W), .NBYTES(NBYTES), .BYTE_W(BYTE_W)) i_wr (
    .clk_i, .rst_ni, .addr_i, .wr_sel_ni, .wdata_i, .wbe_i,
    .stg_v_o(stg_v), .stg_a_o(stg_a), .stg_d0_o(stg_d0), .stg_d1_o(stg_d1),
    .stg_b0_o(stg_b0), .stg_b1_o(stg_b1)
  );

  dbs_array #(.ADDR_W(ADDR_W), .NBYTES(NBYTES), .BYTE_W(BYTE_W)) i_arr (
    .clk_i, .rst_ni,
    .cm_v_i(stg_v), .cm_a_i(stg_a), .cm_d0_i(stg_d0), .cm_d1_i(stg_d1),
    .cm_b0_i(stg_b0), .cm_b1_i(stg_b1),
    .rd_a0_i(arr_a0), .rd_a1_i(arr_a1), .rd_d0_o(arr_d0), .rd_d1_o(arr_d1)
  );

  dbs_rd_path #(.ADDR_W(ADDR_W), .NBYTES(NBYTES), .BYTE_W(BYTE_W)) i_rd (
    .clk_i, .rst_ni, .addr_i, .rd_sel_ni,
    .stg_v_i(stg_v), .stg_a_i(stg_a), .stg_d0_i(stg_d0), .stg_b0_i(stg_b0),
    .arr_d0_i(arr_d0), .arr_d1_i(arr_d1),
    .arr_a0_o(arr_a0), .arr_a1_o(arr_a1), .rdata_o, .rvalid_o
  );
endmodule

// File: rtl/dbs_checker.sv
`timescale 1ns/1ps
module dbs_checker #(
  parameter int unsigned DW = 16
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          rd_sel_ni,
  input logic [DW-1:0] rdata_o,
  input logic          rvalid_o
);
  AST_RD_LATENCY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_sel_ni |=> ##1 rvalid_o);  // R1
  AST_RD_DESELECT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_sel_ni |=> ##1 !rvalid_o);  // R3
  AST_IDLE_WORD0: assert property (@(negedge clk_i) disable iff (!rst_ni)
    !rvalid_o |-> (rdata_o == '0));  // R8
  AST_IDLE_WORD1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rvalid_o |-> (rdata_o == '0));  // R8
  always @(negedge clk_i) begin
    if (!rst_ni) AST_RESET_NO_VALID: assert (!rvalid_o);  // R9
  end
endmodule

bind ddr_burst_sram dbs_checker #(.DW(DW)) i_dbs_checker (
  .clk_i(clk_i), .rst_ni(rst_ni), .rd_sel_ni(rd_sel_ni),
  .rdata_o(rdata_o), .rvalid_o(rvalid_o)
);

// File: tb/test_ddr_burst_sram.sv
`timescale 1ns/1ps
module test_ddr_burst_sram;
  localparam int AW = 4, NB = 2, BW = 8, DW = NB * BW, DEPTH = 1 << AW;
  localparam int N = 400;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [AW-1:0] addr = '0;
  logic rd_sel_n = 1'b1, wr_sel_n = 1'b1;
  logic [DW-1:0] wdata = '0;
  logic [NB-1:0] wbe = '0;
  logic [DW-1:0] rdata;
  logic rvalid;

  ddr_burst_sram #(.ADDR_W(AW), .NBYTES(NB), .BYTE_W(BW)) i_ddr_burst_sram (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .rd_sel_ni(rd_sel_n),
    .wr_sel_ni(wr_sel_n), .wdata_i(wdata), .wbe_i(wbe),
    .rdata_o(rdata), .rvalid_o(rvalid)
  );

  always #4 clk = ~clk;

  // per-cycle stimulus and expectations
  logic          rd_en [N];
  logic [AW-1:0] rd_a  [N];
  logic          wr_en [N];
  logic [AW-1:0] wr_a  [N];
  logic [DW-1:0] wd0 [N], wd1 [N];
  logic [NB-1:0] wb0 [N], wb1 [N];
  logic [DW-1:0] exp0 [N], exp1 [N];
  string         tag [N];
  logic [DW-1:0] ref0 [DEPTH], ref1 [DEPTH];

  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;

  task automatic chk(string req, string what, logic [DW:0] act, logic [DW:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h at %0t", req, what, act, exp, $time);
    end
  endtask

  task automatic set_cyc(int n, logic re, logic [AW-1:0] ra, logic we, logic [AW-1:0] wa,
                         logic [DW-1:0] d0, logic [DW-1:0] d1, logic [NB-1:0] b0,
                         logic [NB-1:0] b1, string t);
    rd_en[n] = re; rd_a[n] = ra; wr_en[n] = we; wr_a[n] = wa;
    wd0[n] = d0; wd1[n] = d1; wb0[n] = b0; wb1[n] = b1; tag[n] = t;
  endtask

  // check the burst returned in cycle n for the read of cycle n-1
  task automatic check_beat(int n, bit hi);
    string t;
    logic  v;
    logic [DW-1:0] e;
    t = (n >= 1) ? tag[n-1] : "R9";
    v = (n >= 1) ? rd_en[n-1] : 1'b0;
    e = v ? (hi ? exp0[n-1] : exp1[n-1]) : '0;
    chk(t, hi ? "rvalid hi-phase" : "rvalid lo-phase", {{DW{1'b0}}, rvalid}, {{DW{1'b0}}, v});
    chk(v ? t : "R8", hi ? "word0" : "word1", {1'b0, rdata}, {1'b0, e});
  endtask

  initial begin
    // idle default
    for (int n = 0; n < N; n++) set_cyc(n, 0, 0, 0, 0, 16'h0BAD, 16'h0DAD, 2'b11, 2'b11, "R8");
    // directed
    set_cyc(1, 0, 0, 1, 2, 16'h1111, 16'h2222, 2'b11, 2'b11, "R2");
    set_cyc(3, 1, 2, 0, 0, 16'h0, 16'h0, 2'b00, 2'b00, "R2");           // committed write, R1 beats
    set_cyc(4, 0, 0, 1, 5, 16'hAAAA, 16'hBBBB, 2'b11, 2'b11, "R6");
    set_cyc(5, 1, 5, 0, 0, 16'h0, 16'h0, 2'b00, 2'b00, "R6");           // staged write bypass
    set_cyc(6, 1, 5, 1, 5, 16'hCCCC, 16'hDDDD, 2'b11, 2'b11, "R7");     // same-cycle write unseen
    set_cyc(7, 1, 5, 0, 0, 16'h0, 16'h0, 2'b00, 2'b00, "R6");
    set_cyc(8, 0, 0, 1, 5, 16'h1234, 16'h5678, 2'b01, 2'b10, "R5");
    set_cyc(9, 1, 5, 0, 0, 16'h0, 16'h0, 2'b00, 2'b00, "R5");           // CC34 / 56DD
    set_cyc(10, 0, 0, 0, 5, 16'hEEEE, 16'hFFFF, 2'b11, 2'b11, "R4");
    set_cyc(11, 0, 5, 0, 5, 16'hEEEE, 16'hFFFF, 2'b11, 2'b11, "R4");
    set_cyc(12, 1, 5, 0, 0, 16'h0, 16'h0, 2'b00, 2'b00, "R4");          // deselected writes ignored
    set_cyc(13, 0, 5, 0, 0, 16'h0, 16'h0, 2'b00, 2'b00, "R3");
    set_cyc(14, 1, 2, 0, 0, 16'h0, 16'h0, 2'b00, 2'b00, "R1");
    set_cyc(15, 1, 5, 1, 7, 16'hFFFF, 16'hFFFF, 2'b00, 2'b00, "R1");
    set_cyc(16, 1, 7, 0, 0, 16'h0, 16'h0, 2'b00, 2'b00, "R5");          // all enables low
    set_cyc(17, 1, 9, 0, 0, 16'h0, 16'h0, 2'b00, 2'b00, "R9");          // never written
    // random traffic on a narrow address range, R6 coherency
    for (int n = 20; n < N - 2; n++)
      set_cyc(n, ($urandom % 4) != 0, AW'($urandom % 4), ($urandom % 3) != 0, AW'($urandom % 4),
              DW'($urandom), DW'($urandom), NB'($urandom), NB'($urandom), "R6");
    // behavioural model: write j is visible to reads from cycle j+1
    for (int i = 0; i < DEPTH; i++) begin ref0[i] = '0; ref1[i] = '0; end
    for (int n = 0; n < N; n++) begin
      if (n >= 1 && wr_en[n-1])
        for (int b = 0; b < NB; b++) begin
          if (wb0[n-1][b]) ref0[wr_a[n-1]][b*BW +: BW] = wd0[n-1][b*BW +: BW];
          if (wb1[n-1][b]) ref1[wr_a[n-1]][b*BW +: BW] = wd1[n-1][b*BW +: BW];
        end
      exp0[n] = ref0[rd_a[n]];
      exp1[n] = ref1[rd_a[n]];
    end

    // reset, R9
    repeat (3) @(posedge clk);
    #2;
    chk("R9", "rvalid in reset", {{DW{1'b0}}, rvalid}, '0);
    chk("R9", "rdata in reset", {1'b0, rdata}, '0);
    @(negedge clk); #2;
    rst_n = 1'b1;
    addr = rd_a[0]; rd_sel_n = ~rd_en[0]; wdata = '0; wbe = '0;
    for (int n = 0; n < N; n++) begin
      @(posedge clk); #2;
      check_beat(n, 1'b1);
      addr = wr_a[n]; wr_sel_n = ~wr_en[n];
      wdata = (n >= 1) ? wd1[n-1] : '0;
      wbe   = (n >= 1) ? wb1[n-1] : '0;
      #4;
      check_beat(n, 1'b0);
      if (n + 1 < N) begin addr = rd_a[n+1]; rd_sel_n = ~rd_en[n+1]; end
      else rd_sel_n = 1'b1;
      wdata = wd0[n]; wbe = wb0[n];
    end
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual hung expected finish");
      end
    join_any
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule